// File: doc/BRIEF.md
# Nonce Response CRC5 Checker

This block verifies the integrity of the seven-byte result frames that a hashing chip sends back over its serial response line. A byte stream, already deserialised, enters through a valid/data pair. The block counts bytes into frames. It runs a five-bit cyclic redundancy check over the leading six bytes plus three padding bits. It then compares the result with the frame's closing checksum byte. For every frame it raises either a pass strobe or a fail strobe for one cycle, together with the 32-bit nonce carried at the head of the frame.

The CRC engine consumes one bit per clock, so each frame takes about fifty cycles to check. A one-frame holding slot sits between the byte collector and the engine. The collector can therefore take in the next frame while the current one is still being checked. A synchronous frame-reset input lets surrounding logic drop a partial frame, for example after a timeout on the serial line.

The engine is a state machine with three states. IDLE waits for a held frame. The launch transition (IDLE to SHIFT) loads the held frame when one is waiting. SHIFT stays in SHIFT through fifty of the 51 CRC bits, and the last-bit transition (SHIFT to CHECK) leaves after the 51st bit. CHECK compares and reports, and the report transition (CHECK to IDLE) returns the engine to IDLE.

Top module: `nonce_crc_checker`

## Requirements
- R1: A frame is exactly seven bytes. A byte is taken only in a cycle with `in_valid` high, cycles with `in_valid` low are skipped, and the seventh byte of a frame is the checksum. No result is produced for a frame with fewer than seven bytes.
- R2: The CRC uses the polynomial x^5+x^2+1 with the register preset to 5'h1F. Bits are fed most significant first: the 48 bits of bytes 0 to 5 in order, then the three bits 1, 0, 0 (the upper bits of a 0x80 pad byte), 51 bits in all.
- R3: The compare byte is the 5-bit CRC in bits 4:0, zero in bits 6:5 and one in bit 7. When it equals the checksum byte, `res_ok` is high for exactly one cycle.
- R4: Any other checksum value produces a one-cycle `res_err`. This includes the bare CRC value with bit 7 clear, a checksum with bit 5 set, and a checksum with one flipped CRC bit.
- R5: `res_ok` and `res_err` are never high together, each frame yields exactly one strobe, and the strobe lasts one cycle.
- R6: `res_nonce` equals bytes 0 to 3 of the frame, with byte 0 in bits 31:24. It is updated in the cycle the strobe rises and holds until the next result.
- R7: `frame_rst` discards any partial frame. A byte offered in the same cycle as `frame_rst` is discarded too, and the next seven accepted bytes form a fresh frame.
- R8: A result strobe appears between 51 and 60 clock cycles after the clock edge that accepts the seventh byte of an otherwise idle checker.
- R9: Two frames delivered back to back, with no idle cycle between them, are both checked and reported in arrival order.
- R10: While `rst_n` is low, both strobes and `res_nonce` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_rst | input | 1 | Drops the partial frame being collected |
| in_valid | input | 1 | `in_data` carries a frame byte this cycle |
| in_data | input | 8 | Frame byte |
| res_ok | output | 1 | One-cycle pulse: checksum matched |
| res_err | output | 1 | One-cycle pulse: checksum mismatched |
| res_nonce | output | 32 | Nonce of the frame last reported |

## Verification
The overflow property assumes that a completed frame never finds the holding slot occupied by a frame the engine has not yet taken. In practice, completed frames must be spaced by at least the engine's check time, apart from a single frame that may arrive while the engine is busy. The stimulus respects this: frames are sent one at a time and the bench waits for each result, with a single back-to-back pair followed by a wait for both results. The minimum-latency property counts cycles from the engine's launch, and it takes as given that a launch only happens from the idle state.

// File: rtl/nonce_crc_pkg.sv
`timescale 1ns/1ps
package nonce_crc_pkg;

    // Engine sequencing states
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_CHECK = 2'd2
    } eng_state_t;

endpackage

// File: rtl/nonce_frame_collect.sv
`timescale 1ns/1ps
module nonce_frame_collect #(
    parameter int FRAME_BYTES = 7,
    parameter int BYTE_W      = 8,
    localparam int FB         = FRAME_BYTES * BYTE_W,
    localparam int CNT_W      = $clog2(FRAME_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_rst,
    input  logic          in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic          frame_done,
    output logic [FB-1:0] frame_data
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

    logic [CNT_W-1:0] byte_cnt;

    // Byte counter and shift buffer; byte 0 ends up in the top bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_cnt   <= '0;
            frame_done <= 1'b0;
            frame_data <= '0;
        end else begin
            frame_done <= 1'b0;
            if (frame_rst) begin
                byte_cnt <= '0;
            end else if (in_valid) begin
                frame_data <= {frame_data[FB-BYTE_W-1:0], in_data};
                if (byte_cnt == LAST_IDX) begin
                    byte_cnt   <= '0;
                    frame_done <= 1'b1;
                end else begin
                    byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/nonce_crc_engine.sv
`timescale 1ns/1ps
module nonce_crc_engine
    import nonce_crc_pkg::*;
#(
    parameter int FRAME_BYTES = 7,
    parameter int BYTE_W      = 8,
    parameter int NONCE_BYTES = 4,
    parameter int CRC_W       = 5,
    parameter logic [CRC_W-1:0] POLY = 5'h05,
    parameter logic [CRC_W-1:0] INIT = 5'h1F,
    parameter int PAD_BITS    = 3,
    parameter logic [BYTE_W-1:0] PAD_BYTE = 8'h80,
    localparam int FB         = FRAME_BYTES * BYTE_W,
    localparam int NONCE_W    = NONCE_BYTES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FB-1:0]      frame_data,
    output logic               idle,
    output logic               res_ok,
    output logic               res_err,
    output logic [NONCE_W-1:0] res_nonce
);

    localparam int DATA_BITS = (FRAME_BYTES - 1) * BYTE_W;
    localparam int CRC_BITS  = DATA_BITS + PAD_BITS;
    localparam int BIT_CNT_W = $clog2(CRC_BITS);
    localparam int ZERO_W    = BYTE_W - 1 - CRC_W;
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(CRC_BITS - 1);

    eng_state_t state, state_nx;

    logic [CRC_BITS-1:0]  shreg;
    logic [CRC_W-1:0]     crc, crc_nx;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    chk_byte;
    logic [NONCE_W-1:0]   nonce_q;
    logic [BYTE_W-1:0]    cmp_byte;
    logic                 fb;
    logic                 match;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    // Transitions: launch, last-bit, report
    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_IDLE:  if (start) state_nx = ENG_SHIFT;
            ENG_SHIFT: if (bit_cnt == LAST_BIT) state_nx = ENG_CHECK;
            ENG_CHECK: state_nx = ENG_IDLE;
            default:   state_nx = ENG_IDLE;
        endcase
    end

    // One serial CRC step, MSB of the shift register first
    always_comb begin
        fb     = shreg[CRC_BITS-1] ^ crc[CRC_W-1];
        crc_nx = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign cmp_byte = {1'b1, {ZERO_W{1'b0}}, crc};
    assign match    = (cmp_byte == chk_byte);
    assign idle     = (state == ENG_IDLE);

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            crc      <= INIT;
            bit_cnt  <= '0;
            chk_byte <= '0;
            nonce_q  <= '0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (start) begin
                        shreg    <= {frame_data[FB-1 -: DATA_BITS],
                                     PAD_BYTE[BYTE_W-1 -: PAD_BITS]};
                        crc      <= INIT;
                        bit_cnt  <= '0;
                        chk_byte <= frame_data[BYTE_W-1:0];
                        nonce_q  <= frame_data[FB-1 -: NONCE_W];
                    end
                end
                ENG_SHIFT: begin
                    crc     <= crc_nx;
                    shreg   <= {shreg[CRC_BITS-2:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ENG_CHECK: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_ok    <= 1'b0;
            res_err   <= 1'b0;
            res_nonce <= '0;
        end else begin
            res_ok  <= 1'b0;
            res_err <= 1'b0;
            if (state == ENG_CHECK) begin
                res_ok    <= match;
                res_err   <= !match;
                res_nonce <= nonce_q;
            end
        end
    end

endmodule

// File: rtl/nonce_crc_checker.sv
`timescale 1ns/1ps
module nonce_crc_checker #(
    parameter int FRAME_BYTES = 7,
    parameter int BYTE_W      = 8,
    parameter int NONCE_BYTES = 4,
    parameter int CRC_W       = 5,
    parameter logic [CRC_W-1:0] POLY = 5'h05,
    parameter logic [CRC_W-1:0] INIT = 5'h1F,
    parameter int PAD_BITS    = 3,
    parameter logic [BYTE_W-1:0] PAD_BYTE = 8'h80
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_rst,
    input  logic                          in_valid,
    input  logic [BYTE_W-1:0]             in_data,
    output logic                          res_ok,
    output logic                          res_err,
    output logic [NONCE_BYTES*BYTE_W-1:0] res_nonce
);

    localparam int FB = FRAME_BYTES * BYTE_W;

    logic          frame_done;
    logic [FB-1:0] frame_data;
    logic          pend_valid;
    logic [FB-1:0] pend_frame;
    logic          eng_idle;
    logic          eng_start;

    nonce_frame_collect #(
        .FRAME_BYTES(FRAME_BYTES),
        .BYTE_W     (BYTE_W)
    ) u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_rst (frame_rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .frame_done(frame_done),
        .frame_data(frame_data)
    );

    // One-frame holding slot between collector and engine
    assign eng_start = eng_idle && pend_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_frame <= '0;
        end else begin
            pend_valid <= frame_done || (pend_valid && !eng_start);
            if (frame_done) pend_frame <= frame_data;
        end
    end

    nonce_crc_engine #(
        .FRAME_BYTES(FRAME_BYTES),
        .BYTE_W     (BYTE_W),
        .NONCE_BYTES(NONCE_BYTES),
        .CRC_W      (CRC_W),
        .POLY       (POLY),
        .INIT       (INIT),
        .PAD_BITS   (PAD_BITS),
        .PAD_BYTE   (PAD_BYTE)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .frame_data(pend_frame),
        .idle      (eng_idle),
        .res_ok    (res_ok),
        .res_err   (res_err),
        .res_nonce (res_nonce)
    );

endmodule

// File: rtl/nonce_crc_sva.sv
`timescale 1ns/1ps
module nonce_crc_sva #(
    parameter int NONCE_W  = 32,
    parameter int CRC_BITS = 51
) (
    input logic               clk,
    input logic               rst_n,
    input logic               res_ok,
    input logic               res_err,
    input logic [NONCE_W-1:0] res_nonce,
    input logic               frame_done,
    input logic               pend_valid,
    input logic               eng_start
);

    logic [7:0] lat_cnt;

    // Cycles since the last engine launch, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                lat_cnt <= 8'd0;
        else if (eng_start)        lat_cnt <= 8'd0;
        else if (lat_cnt != 8'hFF) lat_cnt <= lat_cnt + 8'd1;
    end

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_ok && res_err)); // R5

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ok || res_err) |=> !(res_ok || res_err)); // R5

    AST_NONCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_ok || res_err) |-> $stable(res_nonce)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && pend_valid) |-> eng_start); // R9

    AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_ok || res_err) |-> (lat_cnt >= 8'(CRC_BITS))); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(res_ok || res_err)); // R10

endmodule

bind nonce_crc_checker nonce_crc_sva #(
    .NONCE_W (NONCE_BYTES * BYTE_W),
    .CRC_BITS((FRAME_BYTES - 1) * BYTE_W + PAD_BITS)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_ok    (res_ok),
    .res_err   (res_err),
    .res_nonce (res_nonce),
    .frame_done(frame_done),
    .pend_valid(pend_valid),
    .eng_start (eng_start)
);

// File: tb/nonce_crc_checker_test.sv
`timescale 1ns/1ps
module nonce_crc_checker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_rst = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        res_ok;
    logic        res_err;
    logic [31:0] res_nonce;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    nonce_crc_checker uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_rst(frame_rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .res_ok   (res_ok),
        .res_err  (res_err),
        .res_nonce(res_nonce)
    );

    // {six data bytes, checksum kind}: 0 good, 1 bit7 clear, 2 crc bit flipped, 3 bit5 set
    localparam logic [49:0] VEC [0:5] = '{
        {48'h1234_5678_9ABC, 2'd0},
        {48'h0000_0000_0000, 2'd0},
        {48'hFFFF_FFFF_FFFF, 2'd1},
        {48'hDEAD_BEEF_0102, 2'd2},
        {48'h8000_0001_7F00, 2'd3},
        {48'hA5C3_3C5A_0F10, 2'd0}
    };

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    function automatic logic [4:0] ref_crc(input logic [47:0] d);
        logic [4:0] c;
        logic       b;
        logic       f;
        c = 5'h1F;
        for (int i = 50; i >= 0; i--) begin
            b = (i >= 3) ? d[i-3] : (i == 2);
            f = b ^ c[4];
            c = {c[3:0], 1'b0} ^ (f ? 5'h05 : 5'h00);
        end
        return c;
    endfunction

    function automatic logic [7:0] make_chk(input logic [47:0] d, input logic [1:0] kind);
        logic [7:0] g;
        g = {3'b100, ref_crc(d)};
        case (kind)
            2'd0:    return g;
            2'd1:    return g & 8'h7F;
            2'd2:    return g ^ 8'h01;
            default: return g | 8'h20;
        endcase
    endfunction

    task automatic send_frame(input logic [55:0] f, input int gap);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = f[55 - 8*i -: 8];
            if (gap > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_result(output bit ok, output bit err,
                               output logic [31:0] nonce, output int lat);
        lat = 1;
        while (!(res_ok || res_err) && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        ok    = res_ok;
        err   = res_err;
        nonce = res_nonce;
        check(!(ok && err), "R5", "both strobes", {30'd0, ok, err}, 32'd0);
        check(ok || err, "R5", "missing strobe", {30'd0, ok, err}, 32'd1);
        @(negedge clk);
        check(!(res_ok || res_err), "R5", "strobe width", {30'd0, res_ok, res_err}, 32'd0);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (res_ok || res_err) seen = 1'b1;
        end
        check(!seen, req, "unexpected strobe", {31'd0, seen}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        report();
    end

    initial begin
        bit          ok, err;
        logic [31:0] nonce;
        int          lat;
        logic [55:0] f;

        // R10: reset state
        repeat (4) @(negedge clk);
        check(res_ok == 1'b0, "R10", "res_ok in reset", {31'd0, res_ok}, 32'd0);
        check(res_err == 1'b0, "R10", "res_err in reset", {31'd0, res_err}, 32'd0);
        check(res_nonce == 32'd0, "R10", "nonce in reset", res_nonce, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R1 R2 R3 R4 R6 R8
        for (int v = 0; v < 6; v++) begin
            f = {VEC[v][49:2], make_chk(VEC[v][49:2], VEC[v][1:0])};
            send_frame(f, v % 3);
            wait_result(ok, err, nonce, lat);
            if (VEC[v][1:0] == 2'd0)
                check(ok && !err, "R3", "good frame", {30'd0, ok, err}, 32'd2);
            else
                check(err && !ok, "R4", "bad frame", {30'd0, ok, err}, 32'd1);
            check(nonce == VEC[v][49:18], "R6", "nonce", nonce, VEC[v][49:18]);
            check(lat >= 51 && lat <= 60, "R8", "latency", lat, 32'd55);
        end

        // R6: nonce holds after the strobe
        repeat (20) @(negedge clk);
        check(res_nonce == VEC[5][49:18], "R6", "nonce held", res_nonce, VEC[5][49:18]);

        // R1 R7: partial frame dropped by frame_rst, then a fresh good frame
        f = {48'h0BAD_F00D_5555, make_chk(48'h0BAD_F00D_5555, 2'd0)};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'hEE;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        frame_rst = 1'b1;
        @(negedge clk);
        frame_rst = 1'b0;
        expect_quiet(70, "R1");
        send_frame(f, 0);
        wait_result(ok, err, nonce, lat);
        check(ok, "R7", "fresh frame after drop", {31'd0, ok}, 32'd1);
        check(nonce == 32'h0BAD_F00D, "R7", "fresh nonce", nonce, 32'h0BAD_F00D);

        // R7: byte offered together with frame_rst is discarded
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'h11;
        end
        @(negedge clk);
        frame_rst = 1'b1;
        in_data   = 8'h22;
        @(negedge clk);
        frame_rst = 1'b0;
        in_valid  = 1'b0;
        f = {48'h7777_0001_ABCD, make_chk(48'h7777_0001_ABCD, 2'd0)};
        send_frame(f, 0);
        wait_result(ok, err, nonce, lat);
        check(ok, "R7", "byte with frame_rst dropped", {31'd0, ok}, 32'd1);
        check(nonce == 32'h7777_0001, "R7", "nonce after same-cycle drop", nonce, 32'h7777_0001);

        // R9: back-to-back pair, good then bad
        f = {48'hC0DE_0001_2345, make_chk(48'hC0DE_0001_2345, 2'd0)};
        send_frame(f, 0);
        f = {48'hC0DE_0002_6789, make_chk(48'hC0DE_0002_6789, 2'd2)};
        send_frame(f, 0);
        wait_result(ok, err, nonce, lat);
        check(ok, "R9", "first of pair ok", {31'd0, ok}, 32'd1);
        check(nonce == 32'hC0DE_0001, "R9", "first of pair nonce", nonce, 32'hC0DE_0001);
        wait_result(ok, err, nonce, lat);
        check(err, "R9", "second of pair err", {31'd0, err}, 32'd1);
        check(nonce == 32'hC0DE_0002, "R9", "second of pair nonce", nonce, 32'hC0DE_0002);
        expect_quiet(70, "R5");

        report();
    end

endmodule